// File: doc/BRIEF.md
# DRAM Slot Arbiter and Address Multiplexer

This block lets a 16-bit CPU and a video/sound scan engine share one DRAM array. A free-running slot timer splits every period of 2×`SLOT_HALF` clock cycles into two halves. The first half always belongs to the CPU. The second half goes to the scan engine when the engine requested it, and otherwise falls back to the CPU. A CPU RAM cycle can only begin on a half boundary that the CPU owns. A CPU that asks for RAM in the wrong half keeps waiting because its acknowledge stays negated.

Each CPU access is handled by a four-state machine. `ST_IDLE` moves to `ST_ROW` on a permitted boundary when AS is asserted and the RAM decode is active. `ST_ROW` holds RAS with the row address for `ROW_CYC` cycles and then moves to `ST_COL`. `ST_COL` adds one bank's byte-lane CAS strobes with the column address for `COL_CYC` cycles and then moves to `ST_HOLD`. `ST_HOLD` drives the acknowledge low until AS is released, and then returns to `ST_IDLE`. The routing of CPU address bits onto the ten DRAM address pins and the choice of bank bit both depend on the SIMM-size strap. Because the lowest row pins take the lowest longword address bits, sequential sweeps such as a framebuffer scan step through every DRAM row.

An external override input releases the acknowledge line so another bus master can drive it. The block reports whether it is driving that line on a separate pin.

Top module: `dram_slot_mux`

## Requirements
- R1: An access holds RAS low with the row address for exactly ROW_CYC (default 2) cycles before any CAS falls. CAS then stays low for COL_CYC (default 4) cycles, and RAS stays low throughout that time.
- R2: Row address: ram_addr_o[6:0] carries A8..A2, bit 7 carries A9 and bit 8 carries A10. Bit 9 carries A19 for 1MB SIMMs and is 0 otherwise. The row address is also presented while the block is idle or holding.
- R3: Column address: bit 0 carries A1, bits 6:1 carry A16..A11 and bit 8 carries A18. Bit 7 carries A10 for 64K SIMMs and A17 for the other sizes. Bit 9 carries A20 for 1MB SIMMs and is 0 otherwise.
- R4: The size strap is encoded as 0 = 64K, 1 = 256K, and 2 or 3 = 1MB.
- R5: The bank bit is A17 for 64K, A19 for 256K and A21 for 1MB. In the column phase only the selected bank's lines may fall. cas_n_o[3] is bank 1 upper (follows UDS), [2] is bank 1 lower (follows LDS), [1] is bank 0 upper and [0] is bank 0 lower.
- R6: After reset, slot_o is low for cycles 0..SLOT_HALF-1 of every 2×SLOT_HALF period. For the second half it is high exactly when scan_req_i was high at the clock edge that starts that half.
- R7: A CPU access begins (RAS falls) only on the first cycle of a half where slot_o is low. RAS and all CAS lines stay high whenever slot_o is high.
- R8: While the override is low, dtack_n_o is driven low from the first cycle after the column phase until the cycle after AS is seen high. At all other times it is driven high.
- R9: While ext_ack_ovr_i is high, dtack_drive_o is 0 and dtack_n_o is released to high impedance. Otherwise dtack_drive_o is 1.
- R10: we_n_o is low during the row and column phases of an access whose rw_i is 0, and high at all other times.
- R11: During and after reset with no request, slot_o is 0, RAS, WE and all CAS lines are high, and dtack is driven high.
- R12: When ram_sel_i is low, a low AS starts no access. RAS, CAS and WE stay high and dtack stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | ADDR_W-1 | CPU word address A[ADDR_W-1:1] |
| as_n_i | input | 1 | CPU address strobe, active low |
| uds_n_i | input | 1 | Upper data strobe, active low |
| lds_n_i | input | 1 | Lower data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| ram_sel_i | input | 1 | Address decode says RAM |
| size_i | input | 2 | SIMM-size strap |
| scan_req_i | input | 1 | Scan engine wants the next second half |
| ext_ack_ovr_i | input | 1 | External master takes the acknowledge line |
| ram_addr_o | output | 10 | Multiplexed DRAM address |
| ras_n_o | output | 1 | Shared row strobe |
| cas_n_o | output | 4 | Column strobes per bank and byte lane |
| we_n_o | output | 1 | DRAM write enable |
| slot_o | output | 1 | 0 = CPU half, 1 = scan half |
| dtack_n_o | output | 1 | CPU acknowledge, tristated on override |
| dtack_drive_o | output | 1 | 1 while the block drives dtack_n_o |

## Verification
Accesses are run with the scan request held low, held high and toggled every cycle. Holding it low shows that CPU cycles may start at mid-period. Holding it high shows that requests wait for the next period start. Toggling exercises the sampling instant. Every size strap is used with addresses that set single high bits (A10, A17..A21) and mixed patterns, so a swapped row/column bit or a wrong bank choice shows up as a distinct address or CAS miscompare. Byte-lane combinations, writes, a non-RAM decode and an override asserted in mid-access separate the strobe-select, write-enable and acknowledge-release paths.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic [1:0] {
        SZ_64K    = 2'd0,
        SZ_256K   = 2'd1,
        SZ_1M     = 2'd2,
        SZ_1M_ALT = 2'd3
    } simm_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_HOLD = 2'd3
    } acc_state_e;

endpackage

// File: rtl/dsm_slot_timer.sv
module dsm_slot_timer #(
    parameter int SLOT_HALF = 8
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic scan_req_i,
    output logic slot_o,
    output logic cpu_go_o
);
    localparam int PERIOD = 2 * SLOT_HALF;
    localparam int CW     = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST_CPU  = CW'(SLOT_HALF - 1);
    localparam logic [CW-1:0] LAST_SCAN = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          scan_own_q;
    logic          end_first, end_second;

    assign end_first  = (cnt_q == LAST_CPU);
    assign end_second = (cnt_q == LAST_SCAN);

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            scan_own_q <= 1'b0;
        end else begin
            cnt_q <= end_second ? '0 : cnt_q + 1'b1;
            if (end_first)
                scan_own_q <= scan_req_i;
            else if (end_second)
                scan_own_q <= 1'b0;
        end
    end

    // the half starting at the next edge belongs to the CPU
    assign cpu_go_o = end_second | (end_first & ~scan_req_i);
    assign slot_o   = scan_own_q;
endmodule

// File: rtl/dsm_addr_mux.sv
module dsm_addr_mux
    import dsm_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:1] addr_i,
    input  logic [1:0]        size_i,
    input  logic              col_sel_i,
    output logic [9:0]        ra_o,
    output logic              bank_o
);
    localparam int LOW_BITS = 7;

    logic [9:0] ra_row, ra_col;
    logic       is64k, is1m;

    assign is64k = (simm_size_e'(size_i) == SZ_64K);
    assign is1m  = size_i[1];

    genvar gi;
    generate
        for (gi = 0; gi < LOW_BITS; gi++) begin : g_row
            assign ra_row[gi] = addr_i[gi + 2];
        end
        for (gi = 1; gi < LOW_BITS; gi++) begin : g_col
            assign ra_col[gi] = addr_i[gi + 10];
        end
    endgenerate

    assign ra_row[7] = addr_i[9];
    assign ra_row[8] = addr_i[10];
    assign ra_row[9] = is1m & addr_i[19];

    assign ra_col[0] = addr_i[1];
    assign ra_col[7] = is64k ? addr_i[10] : addr_i[17];
    assign ra_col[8] = addr_i[18];
    assign ra_col[9] = is1m & addr_i[20];

    assign ra_o   = col_sel_i ? ra_col : ra_row;
    assign bank_o = is64k ? addr_i[17] : (is1m ? addr_i[21] : addr_i[19]);
endmodule

// File: rtl/dsm_cas_dec.sv
module dsm_cas_dec #(
    parameter int BANKS = 2
) (
    input  logic             en_i,
    input  logic             bank_i,
    input  logic             uds_n_i,
    input  logic             lds_n_i,
    output logic [2*BANKS-1:0] cas_n_o
);
    genvar b;
    generate
        for (b = 0; b < BANKS; b++) begin : g_bank
            logic hit;
            assign hit              = en_i & (bank_i == b[0]);
            assign cas_n_o[2*b + 1] = ~(hit & ~uds_n_i);
            assign cas_n_o[2*b]     = ~(hit & ~lds_n_i);
        end
    endgenerate
endmodule

// File: rtl/dram_slot_mux.sv
module dram_slot_mux
    import dsm_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SLOT_HALF = 8,
    parameter int ROW_CYC   = 2,
    parameter int COL_CYC   = 4
) (
    input  logic              clk_i,
    input  logic              rst_n,
    input  logic [ADDR_W-1:1] cpu_addr_i,
    input  logic              as_n_i,
    input  logic              uds_n_i,
    input  logic              lds_n_i,
    input  logic              rw_i,
    input  logic              ram_sel_i,
    input  logic [1:0]        size_i,
    input  logic              scan_req_i,
    input  logic              ext_ack_ovr_i,
    output logic [9:0]        ram_addr_o,
    output logic              ras_n_o,
    output logic [3:0]        cas_n_o,
    output logic              we_n_o,
    output logic              slot_o,
    output logic              dtack_n_o,
    output logic              dtack_drive_o
);
    localparam int MAXC = (ROW_CYC > COL_CYC) ? ROW_CYC : COL_CYC;
    localparam int KW   = $clog2(MAXC + 1);
    localparam logic [KW-1:0] ROW_LAST = KW'(ROW_CYC - 1);
    localparam logic [KW-1:0] COL_LAST = KW'(COL_CYC - 1);

    acc_state_e state_q, state_d;
    logic [KW-1:0] k_q;
    logic cpu_go, bank, col_sel, cas_en, ack_int_n;

    dsm_slot_timer #(.SLOT_HALF(SLOT_HALF)) u_timer (
        .clk_i      (clk_i),
        .rst_n      (rst_n),
        .scan_req_i (scan_req_i),
        .slot_o     (slot_o),
        .cpu_go_o   (cpu_go)
    );

    dsm_addr_mux #(.ADDR_W(ADDR_W)) u_amux (
        .addr_i    (cpu_addr_i),
        .size_i    (size_i),
        .col_sel_i (col_sel),
        .ra_o      (ram_addr_o),
        .bank_o    (bank)
    );

    dsm_cas_dec #(.BANKS(2)) u_cas (
        .en_i    (cas_en),
        .bank_i  (bank),
        .uds_n_i (uds_n_i),
        .lds_n_i (lds_n_i),
        .cas_n_o (cas_n_o)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
        end else begin
            state_q <= state_d;
            k_q     <= (state_d != state_q) ? '0 : k_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!as_n_i && ram_sel_i && cpu_go) state_d = ST_ROW;
            ST_ROW:  if (k_q == ROW_LAST)                state_d = ST_COL;
            ST_COL:  if (k_q == COL_LAST)                state_d = ST_HOLD;
            ST_HOLD: if (as_n_i)                         state_d = ST_IDLE;
            default:                                     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ras_n_o   = 1'b1;
        col_sel   = 1'b0;
        cas_en    = 1'b0;
        we_n_o    = 1'b1;
        ack_int_n = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_ROW: begin
                ras_n_o = 1'b0;
                we_n_o  = rw_i;
            end
            ST_COL: begin
                ras_n_o = 1'b0;
                col_sel = 1'b1;
                cas_en  = 1'b1;
                we_n_o  = rw_i;
            end
            ST_HOLD: ack_int_n = 1'b0;
            default: ;
        endcase
    end

    assign dtack_drive_o = ~ext_ack_ovr_i;
    assign dtack_n_o     = ext_ack_ovr_i ? 1'bz : ack_int_n;
endmodule

// File: rtl/dsm_checker.sv
module dsm_checker (
    input logic       clk_i,
    input logic       rst_n,
    input logic       as_n_i,
    input logic       ram_sel_i,
    input logic [1:0] size_i,
    input logic       ext_ack_ovr_i,
    input logic [9:0] ram_addr_o,
    input logic       ras_n_o,
    input logic [3:0] cas_n_o,
    input logic       slot_o,
    input logic       dtack_drive_o
);
    AST_CAS_AFTER_RAS: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cas_n_o != 4'hF) |-> (!ras_n_o && !$past(ras_n_o))); // R1

    AST_RA9_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!size_i[1]) |-> (ram_addr_o[9] == 1'b0)); // R3

    AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_n)
        !((cas_n_o[3:2] != 2'b11) && (cas_n_o[1:0] != 2'b11))); // R5

    AST_QUIET_IN_SCAN: assert property (@(posedge clk_i) disable iff (!rst_n)
        slot_o |-> (ras_n_o && (cas_n_o == 4'hF))); // R7

    AST_OVR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n)
        ext_ack_ovr_i |-> !dtack_drive_o); // R9

    AST_START_NEEDS_RAM: assert property (@(posedge clk_i) disable iff (!rst_n)
        $fell(ras_n_o) |-> ($past(ram_sel_i) && !$past(as_n_i))); // R12
endmodule

bind dram_slot_mux dsm_checker u_dsm_checker (
    .clk_i         (clk_i),
    .rst_n         (rst_n),
    .as_n_i        (as_n_i),
    .ram_sel_i     (ram_sel_i),
    .size_i        (size_i),
    .ext_ack_ovr_i (ext_ack_ovr_i),
    .ram_addr_o    (ram_addr_o),
    .ras_n_o       (ras_n_o),
    .cas_n_o       (cas_n_o),
    .slot_o        (slot_o),
    .dtack_drive_o (dtack_drive_o)
);

// File: tb/dram_slot_mux_bench.sv
`timescale 1ns/1ps
module dram_slot_mux_bench;
    localparam int H    = 8;
    localparam int ROWC = 2;
    localparam int COLC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:1] a = '0;
    logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic        ram_sel = 1'b1, scan_req = 1'b0, ovr = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [9:0]  ram_addr;
    logic        ras_n, we_n, slot, dtack_n, dtack_drv;
    logic [3:0]  cas_n;

    int vectors = 0, errors = 0;
    int scan_mode = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_scan = 0, m_st = 0, m_k = 0;

    always #2.5 clk = ~clk;

    dram_slot_mux u_dram_slot_mux (
        .clk_i(clk), .rst_n(rst_n), .cpu_addr_i(a), .as_n_i(as_n),
        .uds_n_i(uds_n), .lds_n_i(lds_n), .rw_i(rw), .ram_sel_i(ram_sel),
        .size_i(size), .scan_req_i(scan_req), .ext_ack_ovr_i(ovr),
        .ram_addr_o(ram_addr), .ras_n_o(ras_n), .cas_n_o(cas_n),
        .we_n_o(we_n), .slot_o(slot), .dtack_n_o(dtack_n),
        .dtack_drive_o(dtack_drv)
    );

    function automatic logic [9:0] exp_ra(input logic [23:1] ad, input int sz, input bit col);
        logic [9:0] r;
        bit big = (sz >= 2);
        if (!col) begin
            r[6:0] = ad[8:2]; r[7] = ad[9]; r[8] = ad[10];
            r[9] = big ? ad[19] : 1'b0;
        end else begin
            r[0] = ad[1]; r[6:1] = ad[16:11];
            r[7] = (sz == 0) ? ad[10] : ad[17];
            r[8] = ad[18];
            r[9] = big ? ad[20] : 1'b0;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
        end
    endtask

    task automatic step();
        bit bnd0, bndh, go;
        int bank;
        logic [3:0] e_cas;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_cnt = 0; m_scan = 0; m_st = 0; m_k = 0;
        end else begin
            bnd0 = (m_cnt == 2*H-1);
            bndh = (m_cnt == H-1);
            go   = bnd0 || (bndh && !scan_req);
            case (m_st)
                0: if (!as_n && ram_sel && go) begin m_st = 1; m_k = 0; end
                1: if (m_k == ROWC-1) begin m_st = 2; m_k = 0; end else m_k++;
                2: if (m_k == COLC-1) begin m_st = 3; m_k = 0; end else m_k++;
                default: if (as_n) begin m_st = 0; m_k = 0; end
            endcase
            if (bndh) m_scan = scan_req;
            else if (bnd0) m_scan = 0;
            m_cnt = (m_cnt + 1) % (2*H);
        end
        bank = (size == 0) ? a[17] : (size == 1) ? a[19] : a[21];
        e_cas = 4'hF;
        if (m_st == 2) begin
            e_cas[2*bank+1] = uds_n;
            e_cas[2*bank]   = lds_n;
        end
        vectors++;
        chk("R6", "slot", slot, m_scan);
        chk("R1/R7/R12", "ras_n", ras_n, !(m_st == 1 || m_st == 2));
        chk("R5", "cas_n", cas_n, e_cas);
        chk("R10", "we_n", we_n, !((m_st == 1 || m_st == 2) && !rw));
        chk(m_st == 2 ? "R3" : "R2", "ram_addr", ram_addr, exp_ra(a, size, m_st == 2));
        chk("R9", "dtack_drive", dtack_drv, !ovr);
        if (!ovr) chk("R8", "dtack_n", dtack_n, !(m_st == 3));
        if (scan_mode == 1) scan_req = 1'b1;
        else if (scan_mode == 2) scan_req = ~scan_req;
        else scan_req = 1'b0;
    endtask

    task automatic access(input logic [23:1] ad, input bit wr, input bit u, input bit l);
        a = ad; rw = !wr; uds_n = !u; lds_n = !l; as_n = 1'b0;
        for (int i = 0; i < 64 && m_st != 3; i++) step();
        step();
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        step();
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        for (int i = 0; i < 4; i++) step();
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) step();

        // R2 R3 R4 R5 R6 R7: every size, every scan pattern
        for (int mode = 0; mode < 3; mode++) begin
            scan_mode = mode;
            for (int sz = 0; sz < 4; sz++) begin
                size = 2'(sz);
                access(23'h000400 >> 1, 0, 1, 1);   // A10
                access(23'h020000 >> 1, 0, 1, 0);   // A17
                access(23'h080000 >> 1, 1, 0, 1);   // A19
                access(23'h100000 >> 1, 0, 1, 1);   // A20
                access(23'h200000 >> 1, 1, 1, 1);   // A21
                access(23'h05A5A6 >> 1, 0, 1, 1);
                access(23'h3C3C3C >> 1, 1, 1, 0);
                access(23'h040002 >> 1, 0, 0, 1);   // A18, A1
            end
        end

        // R12: non-RAM decode starts nothing
        scan_mode = 0;
        ram_sel = 1'b0; as_n = 1'b0;
        for (int i = 0; i < 40; i++) step();
        as_n = 1'b1; ram_sel = 1'b1;
        step();

        // R9 R8: override during an access
        size = 2'd1;
        ovr = 1'b1;
        access(23'h012345, 1, 1, 1);
        ovr = 1'b0;
        access(23'h054321, 0, 1, 1);

        // R10: a long run of writes with a scan request every other cycle
        scan_mode = 2;
        for (int i = 0; i < 6; i++) access(23'(i * 23'h01F3B1), 1, i[0], 1);

        for (int i = 0; i < 8; i++) step();
        finish_run();
    end
endmodule